// File: doc/BRIEF.md
# Gated Interrupt Request Controller

This block gathers event flags from a set of peripheral sources and folds them into a single interrupt request for a small processor core. Every source keeps a sticky flag and a per-source enable. A parameter assigns each source to one of eight modules, and each module has its own enable bit. On top of that, a global enable and an in-service bit gate the whole path. All sources have the same priority and share one programmable vector address, which the block drives to the core at all times.

Software reaches the state through a simple register port: a write strobe with an address and data, and a combinational read-data output. The core pulses `take_ack` when it branches to the vector and pulses `hdl_return` when the handler exits. A handler can clear the in-service bit itself to let a second interrupt nest. Each module also has a read-only pending summary, so a handler can poll which source fired.

Top module: `irq_gate`

## Requirements
- R1: While `rst_n` is low and right after reset, every register reads 0, `vector_addr` is 0x0000, `in_service` is 0 and `irq_req` is 0.
- R2: `irq_req` is 1 exactly when all of these hold: the global enable (address 0, bit 0) is 1, `in_service` is 0, and at least one source has its flag, its local enable and its module's enable all at 1.
- R3: A write to address 4 loads the vector register, and `vector_addr` shows the new value from the next cycle on. The register reads back at address 4.
- R4: A 1 on `hw_evt[i]` sets flag i in the flag register (address 3, bit i). A flag stays at 1 until software writes 0 to that bit. Software can also set a flag by writing 1 to it.
- R5: When a hardware event and a software write of 0 to the same flag happen in the same cycle, the flag ends up at 1.
- R6: A flag that is already pending raises `irq_req` in the cycle after software writes 1 to its local enable (address 2, bit i), provided the other conditions hold.
- R7: With the default parameters, sources 0 to 9 belong to module 0, sources 10 to 14 belong to module 1, and source 15 belongs to module 7. The module enable register at address 1 has one bit per module, with bit m for module m.
- R8: Module enable bits for modules that have no sources (2 to 6) read back as written but do not affect `irq_req`.
- R9: A `take_ack` pulse while `irq_req` is 1 sets `in_service` on that edge, so `irq_req` is 0 in the next cycle.
- R10: A `take_ack` pulse while `irq_req` is 0 does nothing. A `hdl_return` pulse clears `in_service`, and it does nothing when `in_service` is already 0.
- R11: Address 0, bit 1 reads `in_service`. Writing 0 to that bit inside a handler clears it, so a pending request can assert again and nest. A hardware acknowledge in the same cycle takes precedence over a return, and a return takes precedence over the software write.
- R12: Addresses 8+m read module m's pending summary, which is flag AND local enable for the sources in module m, at bit positions equal to the source index. Writes to these addresses are ignored. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DW | Register write data |
| rd_data | output | DW | Combinational read data for `addr` |
| hw_evt | input | N_SRC | Per-source hardware event, one cycle sets the flag |
| take_ack | input | 1 | Core has branched to the vector |
| hdl_return | input | 1 | Handler exit |
| irq_req | output | 1 | Interrupt request to the core |
| in_service | output | 1 | In-service bit |
| vector_addr | output | DW | Shared handler address |

## Verification
A wrong enable, flag or module bit shows up at `irq_req` in the same cycle it is stored, and the register read port shows it at once. A lost set event or a bad write priority leaves a flag reading back as 0, and that error stays visible until the next software write to the flag register. An in-service bit that is wrongly set or wrongly cleared either keeps `irq_req` stuck low or lets a second request through one cycle after the acknowledge or return edge. A bench model tracks every register cycle by cycle, so any such error is caught within the next compared cycle.

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int N_SRC = 16,
  parameter int N_MOD = 8,
  parameter int MW    = 3,
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter logic [N_SRC*MW-1:0] SRC_MOD = {3'd7, {5{3'd1}}, {10{3'd0}}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [N_SRC-1:0] hw_evt,
  input  logic             take_ack,
  input  logic             hdl_return,
  output logic             irq_req,
  output logic             in_service,
  output logic [DW-1:0]    vector_addr
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_MOD  = AW'(1);
  localparam logic [AW-1:0] A_LOC  = AW'(2);
  localparam logic [AW-1:0] A_FLAG = AW'(3);
  localparam logic [AW-1:0] A_VEC  = AW'(4);
  localparam int            PBASE  = 8;

  logic             glb_en_q, ins_q;
  logic [N_MOD-1:0] mod_en_q;
  logic [N_SRC-1:0] loc_en_q, flag_q;
  logic [DW-1:0]    vec_q;
  logic [N_SRC-1:0] mod_ok, live;
  logic [N_SRC-1:0] member [N_MOD];

  genvar gi, gm;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_src
      assign mod_ok[gi] = mod_en_q[SRC_MOD[gi*MW +: MW]];
    end
    for (gm = 0; gm < N_MOD; gm++) begin : g_mod
      for (gi = 0; gi < N_SRC; gi++) begin : g_mem
        assign member[gm][gi] = (SRC_MOD[gi*MW +: MW] == MW'(gm));
      end
    end
  endgenerate

  assign live        = flag_q & loc_en_q & mod_ok;
  assign irq_req     = glb_en_q & ~ins_q & (|live);
  assign in_service  = ins_q;
  assign vector_addr = vec_q;

  wire take = take_ack & irq_req;
  wire wr_ctrl = wr_en && addr == A_CTRL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en_q <= 1'b0;
      ins_q    <= 1'b0;
      mod_en_q <= '0;
      loc_en_q <= '0;
      flag_q   <= '0;
      vec_q    <= '0;
    end else begin
      if (take)            ins_q <= 1'b1;
      else if (hdl_return) ins_q <= 1'b0;
      else if (wr_ctrl)    ins_q <= wr_data[1];
      if (wr_ctrl) glb_en_q <= wr_data[0];
      if (wr_en && addr == A_MOD) mod_en_q <= wr_data[N_MOD-1:0];
      if (wr_en && addr == A_LOC) loc_en_q <= wr_data[N_SRC-1:0];
      if (wr_en && addr == A_VEC) vec_q    <= wr_data;
      if (wr_en && addr == A_FLAG) flag_q <= wr_data[N_SRC-1:0] | hw_evt;
      else                         flag_q <= flag_q | hw_evt;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(addr) >= PBASE && int'(addr) < PBASE + N_MOD)
      rd_data[N_SRC-1:0] = flag_q & loc_en_q & member[int'(addr) - PBASE];
    else
      case (addr)
        A_CTRL: rd_data[1:0]       = {ins_q, glb_en_q};
        A_MOD:  rd_data[N_MOD-1:0] = mod_en_q;
        A_LOC:  rd_data[N_SRC-1:0] = loc_en_q;
        A_FLAG: rd_data[N_SRC-1:0] = flag_q;
        A_VEC:  rd_data            = vec_q;
        default: rd_data = '0;
      endcase
  end
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int N_SRC = 16,
  parameter int DW    = 16,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             wr_en,
  input logic [DW-1:0]    wr_data,
  input logic [N_SRC-1:0] hw_evt,
  input logic [N_SRC-1:0] flag_q,
  input logic             take_ack,
  input logic             hdl_return,
  input logic             irq_req,
  input logic             in_service,
  input logic [DW-1:0]    vector_addr
);
  // R2
  req_blocked_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_service |-> !irq_req);

  // R9
  ack_sets_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ack && irq_req) |=> (in_service && !irq_req));

  // R10
  return_clears_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdl_return && !(take_ack && irq_req)) |=> !in_service);

  // R10
  stray_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ack && !irq_req && !hdl_return && !(wr_en && addr == '0)) |=> $stable(in_service));

  // R4
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt != '0) |=> ((flag_q & $past(hw_evt)) == $past(hw_evt)));

  // R3
  vector_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(4)) |=> (vector_addr == $past(wr_data)));
endmodule

bind irq_gate irq_gate_chk #(.N_SRC(N_SRC), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .hw_evt(hw_evt), .flag_q(flag_q), .take_ack(take_ack), .hdl_return(hdl_return),
  .irq_req(irq_req), .in_service(in_service), .vector_addr(vector_addr)
);

// File: tb/test_irq_gate.sv
module test_irq_gate;
  localparam int NS = 16, NM = 8, DW = 16, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0, rd_data, vector_addr;
  logic [NS-1:0] hw_evt = '0;
  logic          take_ack = 1'b0, hdl_return = 1'b0, irq_req, in_service;

  irq_gate i_irq_gate (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .hw_evt(hw_evt), .take_ack(take_ack),
    .hdl_return(hdl_return), .irq_req(irq_req), .in_service(in_service),
    .vector_addr(vector_addr));

  int errs = 0, checks = 0;
  logic          m_ge = 0, m_ins = 0;
  logic [NM-1:0] m_mod = '0;
  logic [NS-1:0] m_loc = '0, m_flag = '0;
  logic [DW-1:0] m_vec = '0;

  function automatic int src_mod(int i);
    if (i < 10) return 0;
    if (i < 15) return 1;
    return 7;
  endfunction

  function automatic logic exp_irq();
    logic any = 1'b0;
    for (int i = 0; i < NS; i++)
      if (m_flag[i] && m_loc[i] && m_mod[src_mod(i)]) any = 1'b1;
    return m_ge && !m_ins && any;
  endfunction

  function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    if (a >= 8) begin
      for (int i = 0; i < NS; i++)
        if (src_mod(i) == int'(a) - 8) r[i] = m_flag[i] & m_loc[i];
    end else case (a)
      0: r = {14'd0, m_ins, m_ge};
      1: r = {8'd0, m_mod};
      2: r = m_loc;
      3: r = m_flag;
      4: r = m_vec;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [AW-1:0] a, logic we, logic [DW-1:0] d,
                      logic [NS-1:0] ev, logic ak, logic rt);
    logic take;
    @(negedge clk);
    addr = a; wr_en = we; wr_data = d; hw_evt = ev; take_ack = ak; hdl_return = rt;
    #1;
    chk(tag, "rd_data", 32'(rd_data), 32'(exp_rd(a)));
    chk(tag, "irq_req", 32'(irq_req), 32'(exp_irq()));
    chk(tag, "in_service", 32'(in_service), 32'(m_ins));
    chk(tag, "vector_addr", 32'(vector_addr), 32'(m_vec));
    @(posedge clk);
    take = ak && exp_irq();
    if (take) m_ins = 1'b1;
    else if (rt) m_ins = 1'b0;
    else if (we && a == 0) m_ins = d[1];
    if (we && a == 0) m_ge = d[0];
    if (we && a == 1) m_mod = d[NM-1:0];
    if (we && a == 2) m_loc = d;
    if (we && a == 3) m_flag = d;
    if (we && a == 4) m_vec = d;
    m_flag = m_flag | ev;
  endtask

  task automatic rd(string tag, logic [AW-1:0] a);
    step(tag, a, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(20 * 200000);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    // R1 reset state while held
    for (int a = 0; a < 16; a++) begin
      addr = AW'(a); #1;
      chk("R1", "rd_data", 32'(rd_data), 32'd0);
    end
    chk("R1", "irq_req", 32'(irq_req), 32'd0);
    chk("R1", "vector_addr", 32'(vector_addr), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    step("R4", 0, 0, '0, 16'h0008, 0, 0);
    rd("R4", 3);
    step("R2", 0, 1, 16'h0001, '0, 0, 0);
    step("R7", 1, 1, 16'h0001, '0, 0, 0);
    rd("R6", 3);
    step("R6", 2, 1, 16'h0008, '0, 0, 0);
    rd("R6", 0);
    step("R9", 0, 0, '0, '0, 1, 0);
    rd("R9", 0);
    step("R10", 0, 0, '0, '0, 1, 0);
    step("R10", 0, 0, '0, '0, 0, 1);
    rd("R10", 0);
    step("R10", 0, 0, '0, '0, 0, 1);
    step("R11", 0, 0, '0, '0, 1, 0);
    step("R11", 0, 1, 16'h0001, '0, 0, 0);
    rd("R11", 0);
    step("R5", 3, 1, 16'h0000, 16'h0008, 0, 0);
    rd("R5", 3);
    step("R8", 1, 1, 16'h007C, '0, 0, 0);
    rd("R8", 1);
    step("R7", 0, 0, '0, 16'h9000, 0, 0);
    step("R7", 2, 1, 16'h8000, '0, 0, 0);
    step("R7", 1, 1, 16'h0080, '0, 0, 0);
    rd("R12", 15);
    step("R12", 15, 1, 16'hFFFF, '0, 0, 0);
    rd("R12", 15);
    step("R12", 2, 1, 16'h1000, '0, 0, 0);
    step("R12", 1, 1, 16'h0002, '0, 0, 0);
    rd("R12", 9);
    rd("R12", 8);
    rd("R12", 6);
    step("R3", 4, 1, 16'h1234, '0, 0, 0);
    rd("R3", 4);

    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a = AW'($urandom % 16);
      logic we = ($urandom % 3) == 0;
      logic [DW-1:0] d = DW'($urandom);
      logic [NS-1:0] ev = (($urandom % 4) == 0) ? NS'(1) << ($urandom % NS) : '0;
      if (a == 0 && ($urandom % 2) == 0) d[0] = 1'b1;
      step("R2", a, we, d, ev, ($urandom % 4) == 0, ($urandom % 8) == 0);
    end

    summary();
    $finish;
  end
endmodule